// File: doc/BRIEF.md
# JTAG-to-SPI Flash Bridge

This block lets a host reach a serial flash through a user data register of a JTAG test access port. The TAP controller supplies the test clock, the serial input bit, a register select and the capture, shift and update strobes. The bridge turns one scan of that register into one SPI transaction: it drives an active-low chip select, a serial clock and a serial output line toward the flash, and it samples the flash's serial input line.

A scan is a request only when it opens with a four-byte marker. A 16-bit count follows, giving the number of SPI clock cycles. The SPI bits then follow, and the bridge forwards them to the flash in the order they arrive. Whole bytes received from the flash during a request are kept in a local buffer and are not returned in that scan. The host gets them back with a later scan that carries no marker. During that readback scan the bridge shifts out the stored bytes on TDO, and pads with all-ones bytes once the stored bytes are used up. The host therefore pads each request with dummy bytes to leave room for the reply, and reads each reply one scan later.

The bridge has no handshake at its edges. The test clock paces every bit, and the host must keep the shift strobe high for the whole payload.

Top module: `jtag_spi_bridge`

## Requirements
- R1: After `tap_reset`, `spi_cs_n` is 1, `spi_sclk` is 0, `tdo` is 1, and a readback scan returns only 0xFF bytes.
- R2: A scan is a request only if its first 32 shifted bits are the bytes 0x59, 0xA6, 0x59, 0xA6 in that order, each byte sent LSB first. In any other scan the rest is ignored: `spi_cs_n` stays 1, `spi_sclk` does not pulse, and the buffer keeps its contents.
- R3: The 16 bits after the marker, LSB first, give N. The request produces exactly N rising edges on `spi_sclk`. Any shifted bits after the N payload bits are ignored. If N is 0 there is no SPI activity and the buffer is left empty.
- R4: The payload bits reach `spi_mosi` in the order they were shifted in. `spi_mosi` changes only while `tck` is low, so it is stable at every `spi_sclk` rising edge.
- R5: `spi_cs_n` goes low once per request with N > 0. It stays low across all N `spi_sclk` rising edges and returns high on the falling `tck` edge after the last one.
- R6: `spi_miso` is sampled on each `spi_sclk` rising edge and assembled MSB first into bytes. Each complete byte is stored in arrival order, and a trailing partial byte is discarded.
- R7: In a scan without the marker, `tdo` presents the stored bytes MSB first in arrival order, starting at the first shift bit, and then 1s once the stored bytes run out. Readback leaves the buffer unchanged.
- R8: At most `BUF_BYTES` bytes are kept per request. Bytes received beyond that limit are dropped.
- R9: `tap_reset` acts at once, without waiting for a clock edge: `spi_cs_n` rises and `spi_sclk` falls even in the middle of a payload, and the buffer is emptied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock; also the source of the SPI clock |
| tap_reset | input | 1 | Asynchronous TAP reset, active high |
| ur_sel | input | 1 | The bridge's user data register is selected |
| ur_capture | input | 1 | Capture strobe; starts a scan |
| ur_shift | input | 1 | Shift strobe; one bit moves per `tck` rising edge |
| ur_update | input | 1 | Update strobe; ends a scan |
| tdi | input | 1 | Serial data from the host |
| tdo | output | 1 | Serial readback data to the host, changes on falling `tck` |
| spi_cs_n | output | 1 | Flash chip select, active low |
| spi_sclk | output | 1 | Flash serial clock (gated `tck`) |
| spi_mosi | output | 1 | Serial data to the flash |
| spi_miso | input | 1 | Serial data from the flash |

## Verification
The hardest condition to create from the ports is a TAP reset that arrives while the SPI clock is high in the middle of a payload. The chip select must release and the clock must drop at once, not at the next edge. The bench stops its shift loop partway through the payload of a 64-bit request, waits until just after a rising `tck` edge, confirms that `spi_sclk` is high, and then raises `tap_reset`. It checks both SPI outputs one time unit later, and afterwards reads back an empty buffer. A second hard case is a near-miss marker, with the right bytes in the wrong order. The bench sends one right after a valid request and then reads back twice, to show that the first reply survived both the rejected scan and the first readback.

// File: rtl/jsb_pkg.sv
package jsb_pkg;
  localparam int unsigned SYNC_BITS = 32;
  localparam int unsigned BYTE_W    = 8;
  // Marker bytes 0x59,0xA6,0x59,0xA6 shifted LSB first into a right-moving register.
  localparam logic [SYNC_BITS-1:0] SYNC_WORD = 32'hA659_A659;

  typedef enum logic [1:0] {PH_IDLE, PH_SYNC, PH_LEN, PH_PAY} phase_e;
endpackage

// File: rtl/jsb_frame.sv
module jsb_frame
  import jsb_pkg::*;
#(
  parameter int unsigned LEN_W = 16
) (
  input  logic tck,
  input  logic tap_reset,
  input  logic sel,
  input  logic capture,
  input  logic shift,
  input  logic update,
  input  logic tdi,
  output logic pay_bit,
  output logic pay_data,
  output logic frame_start
);
  localparam int unsigned CW = $clog2(SYNC_BITS);

  phase_e               phase;
  logic [CW-1:0]        cnt;
  logic [SYNC_BITS-1:0] sync_sh, sync_nxt;
  logic [LEN_W-1:0]     len_sh, len_nxt, rem;

  assign sync_nxt = {tdi, sync_sh[SYNC_BITS-1:1]};
  assign len_nxt  = {tdi, len_sh[LEN_W-1:1]};

  always_ff @(posedge tck or posedge tap_reset) begin
    if (tap_reset) begin
      phase       <= PH_IDLE;
      cnt         <= '0;
      sync_sh     <= '0;
      len_sh      <= '0;
      rem         <= '0;
      pay_bit     <= 1'b0;
      pay_data    <= 1'b0;
      frame_start <= 1'b0;
    end else begin
      pay_bit     <= 1'b0;
      frame_start <= 1'b0;
      if (sel && capture) begin
        phase <= PH_SYNC;
        cnt   <= '0;
      end else if (sel && update) begin
        phase <= PH_IDLE;
      end else if (sel && shift) begin
        unique case (phase)
          PH_SYNC: begin
            sync_sh <= sync_nxt;
            cnt     <= cnt + 1'b1;
            if (cnt == CW'(SYNC_BITS - 1)) begin
              cnt   <= '0;
              phase <= (sync_nxt == SYNC_WORD) ? PH_LEN : PH_IDLE;
            end
          end
          PH_LEN: begin
            len_sh <= len_nxt;
            cnt    <= cnt + 1'b1;
            if (cnt == CW'(LEN_W - 1)) begin
              rem         <= len_nxt;
              phase       <= PH_PAY;
              frame_start <= 1'b1;
            end
          end
          PH_PAY: begin
            if (rem != '0) begin
              pay_bit  <= 1'b1;
              pay_data <= tdi;
              rem      <= rem - 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R2: a rejected or finished scan never forwards payload bits
  assert_idle_quiet_R2: assert property (@(posedge tck) disable iff (tap_reset)
    (phase == PH_IDLE) |-> !pay_bit);

  // R2: a request only begins after the length phase, which only follows a matched marker
  assert_start_after_len_R2: assert property (@(posedge tck) disable iff (tap_reset)
    frame_start |-> ($past(phase) == PH_LEN));

  // R3: once the count is used up no further bit is forwarded
  assert_count_exhausted_R3: assert property (@(posedge tck) disable iff (tap_reset)
    (phase == PH_PAY && rem == '0) |=> !pay_bit);
endmodule

// File: rtl/jsb_spi.sv
module jsb_spi
  import jsb_pkg::*;
(
  input  logic              tck,
  input  logic              tap_reset,
  input  logic              pay_bit,
  input  logic              pay_data,
  input  logic              spi_miso,
  output logic              spi_cs_n,
  output logic              spi_sclk,
  output logic              spi_mosi,
  output logic              rx_valid,
  output logic [BYTE_W-1:0] rx_byte
);
  localparam int unsigned BW = $clog2(BYTE_W);

  logic              clk_en;
  logic [BW-1:0]     bit_cnt;
  logic [BYTE_W-2:0] rx_sh;

  // Launch side: falling tck edge, so the flash sees stable data at the next rise.
  always_ff @(negedge tck or posedge tap_reset) begin
    if (tap_reset) begin
      clk_en   <= 1'b0;
      spi_mosi <= 1'b0;
    end else begin
      clk_en <= pay_bit;
      if (pay_bit) spi_mosi <= pay_data;
    end
  end

  assign spi_cs_n = ~clk_en;
  assign spi_sclk = tck & clk_en;

  // Capture side: rising tck edge, which is the SPI clock rising edge while enabled.
  always_ff @(posedge tck or posedge tap_reset) begin
    if (tap_reset) begin
      bit_cnt  <= '0;
      rx_sh    <= '0;
      rx_byte  <= '0;
      rx_valid <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      if (!clk_en) begin
        bit_cnt <= '0;
      end else begin
        rx_sh   <= {rx_sh[BYTE_W-3:0], spi_miso};
        bit_cnt <= bit_cnt + 1'b1;
        if (bit_cnt == BW'(BYTE_W - 1)) begin
          rx_byte  <= {rx_sh, spi_miso};
          rx_valid <= 1'b1;
        end
      end
    end
  end

  // R5: chip select is low only while a payload bit is being issued
  assert_cs_tracks_payload_R5: assert property (@(posedge tck) disable iff (tap_reset)
    !spi_cs_n |-> pay_bit);

  // R6: a received byte always follows active SPI clocking
  assert_byte_needs_clocks_R6: assert property (@(posedge tck) disable iff (tap_reset)
    rx_valid |-> $past(clk_en));
endmodule

// File: rtl/jsb_rbuf.sv
module jsb_rbuf
  import jsb_pkg::*;
#(
  parameter int unsigned BUF_BYTES = 2048
) (
  input  logic              tck,
  input  logic              tap_reset,
  input  logic              sel,
  input  logic              capture,
  input  logic              shift,
  input  logic              frame_start,
  input  logic              rx_valid,
  input  logic [BYTE_W-1:0] rx_byte,
  output logic              tdo
);
  localparam int unsigned IW = $clog2(BUF_BYTES);
  localparam int unsigned AW = IW + 1;
  localparam int unsigned BW = $clog2(BYTE_W);
  localparam logic [AW-1:0] CAP = AW'(BUF_BYTES);

  logic [BYTE_W-1:0] mem [BUF_BYTES];
  logic [AW-1:0]     wr_ptr, rd_ptr;
  logic [BW-1:0]     bit_n;
  logic [BYTE_W-1:0] out_sh, head_byte, next_byte;
  logic              wr_ok;

  assign wr_ok = rx_valid && (wr_ptr < CAP);

  always_ff @(posedge tck) begin
    if (wr_ok) mem[wr_ptr[IW-1:0]] <= rx_byte;
  end

  always_comb begin
    head_byte = (wr_ptr != '0)     ? mem[0]                 : '1;
    next_byte = (rd_ptr < wr_ptr)  ? mem[rd_ptr[IW-1:0]]    : '1;
  end

  always_ff @(posedge tck or posedge tap_reset) begin
    if (tap_reset) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      bit_n  <= '0;
      out_sh <= '1;
    end else begin
      if (frame_start)  wr_ptr <= '0;
      else if (wr_ok)   wr_ptr <= wr_ptr + 1'b1;

      if (sel && capture) begin
        out_sh <= head_byte;
        rd_ptr <= AW'(1);
        bit_n  <= '0;
      end else if (sel && shift) begin
        if (bit_n == BW'(BYTE_W - 1)) begin
          out_sh <= next_byte;
          bit_n  <= '0;
          if (rd_ptr < CAP) rd_ptr <= rd_ptr + 1'b1;
        end else begin
          out_sh <= {out_sh[BYTE_W-2:0], 1'b1};
          bit_n  <= bit_n + 1'b1;
        end
      end
    end
  end

  always_ff @(negedge tck or posedge tap_reset) begin
    if (tap_reset) tdo <= 1'b1;
    else           tdo <= out_sh[BYTE_W-1];
  end

  // R8: a full buffer stays full until the next request
  assert_no_overflow_R8: assert property (@(posedge tck) disable iff (tap_reset)
    (wr_ptr == CAP && !frame_start) |=> (wr_ptr == CAP));

  // R7: an empty buffer presents all ones from the first readback bit
  assert_empty_reads_ones_R7: assert property (@(posedge tck) disable iff (tap_reset)
    (sel && capture && wr_ptr == '0) |=> (out_sh == '1));
endmodule

// File: rtl/jtag_spi_bridge.sv
module jtag_spi_bridge
  import jsb_pkg::*;
#(
  parameter int unsigned LEN_W     = 16,
  parameter int unsigned BUF_BYTES = 2048
) (
  input  logic tck,
  input  logic tap_reset,
  input  logic ur_sel,
  input  logic ur_capture,
  input  logic ur_shift,
  input  logic ur_update,
  input  logic tdi,
  output logic tdo,
  output logic spi_cs_n,
  output logic spi_sclk,
  output logic spi_mosi,
  input  logic spi_miso
);
  logic              pay_bit, pay_data, frame_start, rx_valid;
  logic [BYTE_W-1:0] rx_byte;

  jsb_frame #(.LEN_W(LEN_W)) u_frame (
    .tck(tck), .tap_reset(tap_reset), .sel(ur_sel), .capture(ur_capture),
    .shift(ur_shift), .update(ur_update), .tdi(tdi),
    .pay_bit(pay_bit), .pay_data(pay_data), .frame_start(frame_start)
  );

  jsb_spi u_spi (
    .tck(tck), .tap_reset(tap_reset), .pay_bit(pay_bit), .pay_data(pay_data),
    .spi_miso(spi_miso), .spi_cs_n(spi_cs_n), .spi_sclk(spi_sclk),
    .spi_mosi(spi_mosi), .rx_valid(rx_valid), .rx_byte(rx_byte)
  );

  jsb_rbuf #(.BUF_BYTES(BUF_BYTES)) u_rbuf (
    .tck(tck), .tap_reset(tap_reset), .sel(ur_sel), .capture(ur_capture),
    .shift(ur_shift), .frame_start(frame_start), .rx_valid(rx_valid),
    .rx_byte(rx_byte), .tdo(tdo)
  );
endmodule

// File: tb/jtag_spi_bridge_test.sv
module jtag_spi_bridge_test;
  localparam int BUF = 8;
  localparam int NV  = 6;
  // stimulus: payload bit count and data seed; expected: bytes kept in the buffer
  localparam int         VEC_LEN  [NV] = '{8, 24, 13, 96, 0, 1};
  localparam logic [7:0] VEC_SEED [NV] = '{8'hA5, 8'h3C, 8'hF0, 8'h11, 8'h77, 8'h80};
  localparam int         VEC_NB   [NV] = '{1, 3, 1, 8, 0, 0};

  logic tck = 1'b0, tap_reset = 1'b1, ur_sel = 1'b0, ur_capture = 1'b0;
  logic ur_shift = 1'b0, ur_update = 1'b0, tdi = 1'b0, spi_miso;
  logic tdo, spi_cs_n, spi_sclk, spi_mosi;

  jtag_spi_bridge #(.LEN_W(16), .BUF_BYTES(BUF)) uut (
    .tck(tck), .tap_reset(tap_reset), .ur_sel(ur_sel), .ur_capture(ur_capture),
    .ur_shift(ur_shift), .ur_update(ur_update), .tdi(tdi), .tdo(tdo),
    .spi_cs_n(spi_cs_n), .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .spi_miso(spi_miso)
  );

  always #10 tck = ~tck;

  int n_chk = 0, n_fail = 0;
  int rises = 0, cs_falls = 0, cs_bad = 0, mosi_bad = 0, fbit = 0, salt = 0;
  logic last_cs = 1'b1;
  logic mosi_log [0:255];
  logic tx [0:1023];
  logic rx [0:1023];

  function automatic logic [7:0] resp_byte(int k, int s);
    return 8'((k * 29 + s * 11 + 60) & 255);
  endfunction

  function automatic logic [7:0] pay_byte(logic [7:0] seed, int k);
    return 8'((int'(seed) + k * 37) & 255);
  endfunction

  // flash model: MISO stream of resp_byte(0), resp_byte(1), ... MSB first
  always @* begin
    logic [7:0] rb;
    rb = resp_byte(fbit / 8, salt);
    spi_miso = rb[3'(7 - (fbit % 8))];
  end

  always @(negedge spi_sclk or negedge spi_cs_n) begin
    if (!spi_cs_n && last_cs) begin
      fbit = 0;
      cs_falls++;
    end else begin
      fbit++;
    end
    last_cs = spi_cs_n;
  end

  always @(posedge spi_cs_n) last_cs = 1'b1;

  always @(posedge spi_sclk) begin
    if (fbit < 256) mosi_log[fbit] = spi_mosi;
    rises++;
    if (spi_cs_n) cs_bad++;
  end

  always @(spi_mosi) if (tck) mosi_bad++;

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", what, act, exp);
    end
  endtask

  task automatic put_byte_lsb(input int pos, input logic [7:0] b);
    for (int i = 0; i < 8; i++) tx[pos + i] = b[i];
  endtask

  task automatic build_req(input int n, input logic [7:0] seed, input logic [7:0] b0,
                           input logic [7:0] b1, input logic [7:0] b2, input logic [7:0] b3,
                           output int total);
    logic [15:0] len;
    logic [7:0]  pb;
    len = 16'(n);
    put_byte_lsb(0, b0); put_byte_lsb(8, b1); put_byte_lsb(16, b2); put_byte_lsb(24, b3);
    for (int i = 0; i < 16; i++) tx[32 + i] = len[i];
    for (int j = 0; j < n; j++) begin
      pb = pay_byte(seed, j / 8);
      tx[48 + j] = pb[3'(7 - (j % 8))];
    end
    for (int j = 0; j < 8; j++) tx[48 + n + j] = 1'b0;
    total = 48 + n + 8;
  endtask

  task automatic scan(input int n, input int stop_at);
    @(negedge tck); ur_sel = 1'b1; ur_capture = 1'b1;
    for (int i = 0; i < n; i++) begin
      @(negedge tck); ur_capture = 1'b0; ur_shift = 1'b1; tdi = tx[i];
      #5 rx[i] = tdo;
      if (i == stop_at) begin
        @(posedge tck); #3;
        chk(spi_sclk == 1'b1, "R9 sclk high before reset", int'(spi_sclk), 1);
        tap_reset = 1'b1;
        #1;
        chk(spi_cs_n == 1'b1, "R9 cs_n released at once", int'(spi_cs_n), 1);
        chk(spi_sclk == 1'b0, "R9 sclk dropped at once", int'(spi_sclk), 0);
        @(negedge tck); tap_reset = 1'b0; ur_shift = 1'b0; ur_sel = 1'b0;
        repeat (2) @(negedge tck);
        return;
      end
    end
    @(negedge tck); ur_shift = 1'b0; ur_update = 1'b1;
    @(negedge tck); ur_update = 1'b0; ur_sel = 1'b0;
    repeat (2) @(negedge tck);
  endtask

  task automatic readback(input int nbytes);
    for (int i = 0; i < nbytes * 8; i++) tx[i] = 1'b0;
    scan(nbytes * 8, -1);
  endtask

  function automatic logic [7:0] rx_byte_at(int k);
    logic [7:0] b;
    for (int i = 0; i < 8; i++) b[7 - i] = rx[8 * k + i];
    return b;
  endfunction

  task automatic check_readback(input int nbytes, input int kept, input int s, input string tag);
    logic [7:0] exp_b;
    for (int k = 0; k < nbytes; k++) begin
      exp_b = (k < kept) ? resp_byte(k, s) : 8'hFF;
      chk(rx_byte_at(k) == exp_b, tag, int'(rx_byte_at(k)), int'(exp_b));
    end
  endtask

  initial begin
    repeat (150000) @(posedge tck);
    n_fail++;
    $display("FAIL watchdog: actual running expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    int tot, r0, f0, cb0, mb0, bad;
    logic [7:0] pb;
    repeat (3) @(negedge tck);
    // R1: state while held in reset
    chk(spi_cs_n == 1'b1, "R1 cs_n in reset", int'(spi_cs_n), 1);
    chk(spi_sclk == 1'b0, "R1 sclk in reset", int'(spi_sclk), 0);
    chk(tdo == 1'b1, "R1 tdo in reset", int'(tdo), 1);
    tap_reset = 1'b0;
    @(negedge tck);
    readback(2);
    check_readback(2, 0, 0, "R1 readback after reset");

    // vector table: R3 R4 R5 R6 R7 R8
    for (int v = 0; v < NV; v++) begin
      salt = v * 5 + 1;
      r0 = rises; f0 = cs_falls; cb0 = cs_bad; mb0 = mosi_bad;
      build_req(VEC_LEN[v], VEC_SEED[v], 8'h59, 8'hA6, 8'h59, 8'hA6, tot);
      scan(tot, -1);
      chk(rises - r0 == VEC_LEN[v], "R3 spi clock count", rises - r0, VEC_LEN[v]);
      bad = 0;
      for (int j = 0; j < VEC_LEN[v]; j++) begin
        pb = pay_byte(VEC_SEED[v], j / 8);
        if (mosi_log[j] !== pb[3'(7 - (j % 8))]) bad++;
      end
      chk(bad == 0, "R4 mosi bit order", bad, 0);
      chk(mosi_bad == mb0, "R4 mosi moved while tck high", mosi_bad - mb0, 0);
      chk(cs_falls - f0 == (VEC_LEN[v] > 0 ? 1 : 0), "R5 cs_n low windows",
          cs_falls - f0, (VEC_LEN[v] > 0 ? 1 : 0));
      chk(cs_bad == cb0, "R5 sclk rise with cs_n high", cs_bad - cb0, 0);
      chk(spi_cs_n == 1'b1, "R5 cs_n high after request", int'(spi_cs_n), 1);
      readback(VEC_NB[v] + 2);
      check_readback(VEC_NB[v] + 2, VEC_NB[v], salt, "R6 R7 R8 readback byte");
    end

    // R2: valid request, then a marker with the right bytes in the wrong order
    salt = 40;
    build_req(16, 8'h42, 8'h59, 8'hA6, 8'h59, 8'hA6, tot);
    scan(tot, -1);
    salt = 41;
    r0 = rises; f0 = cs_falls;
    build_req(16, 8'h42, 8'h59, 8'h59, 8'hA6, 8'hA6, tot);
    scan(tot, -1);
    chk(rises == r0, "R2 no sclk for bad marker", rises - r0, 0);
    chk(cs_falls == f0, "R2 no cs_n for bad marker", cs_falls - f0, 0);
    readback(4);
    check_readback(4, 2, 40, "R2 buffer kept after bad marker");
    readback(4);
    check_readback(4, 2, 40, "R7 buffer kept after readback");

    // R9: asynchronous reset in the middle of a payload
    salt = 50;
    build_req(64, 8'h0F, 8'h59, 8'hA6, 8'h59, 8'hA6, tot);
    scan(tot, 48 + 10);
    chk(spi_cs_n == 1'b1, "R9 cs_n after reset", int'(spi_cs_n), 1);
    readback(2);
    check_readback(2, 0, 50, "R9 buffer emptied by reset");

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule